// File: doc/BRIEF.md
# Atomic Operation Placement Predictor

This block decides where each atomic memory operation should run: inside the requesting CPU's L1 cache, or at a shared outer level (outer cache or memory). It keeps a small history per tracked 128-byte granule. Each history entry holds the identifier of the CPU that most recently touched the granule and a saturating count of how many accesses in a row came from that CPU. A granule that one CPU keeps hitting is handled locally. A granule that CPUs share, or that has only just been seen, goes to the outer level.

Each request presents a CPU identifier and a byte address with a one-cycle strobe. The history table is direct-mapped on the granule address and carries a tag. Every request reads its entry, computes the new history, and writes the entry back in the same cycle. The placement decision appears on registered outputs one clock later. Table sizing policy, replacement beyond direct mapping, the caches and the coherence protocol all belong to the surrounding design.

Top module: `atomic_place_predictor`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R2: History is tracked per 128-byte granule. Addresses that differ only in bits [6:0] share one entry. The table index is taken from address bits [7 +: log2(ENTRIES)], and the tag is the bits above the index.
- R3: A request whose entry is empty, or whose entry holds a different tag, is placed remotely (`dec_local` = 0). The entry is rewritten with the new tag, the requesting CPU and a count of 1.
- R4: A request that hits an entry owned by a different CPU is placed remotely. The count restarts at 1 and the requesting CPU becomes the owner.
- R5: A request that hits an entry owned by the same CPU increments the count by one.
- R6: A request is placed locally (`dec_local` = 1) only when it hits, its CPU matches the owner, and the incremented count is strictly greater than LIMIT. With the defaults (LIMIT = 2), the third access in a row by one CPU is the first local one.
- R7: The count saturates at 2^CNT_W-1 and never wraps. Further same-CPU accesses stay local.
- R8: Synchronous active-high reset empties every entry and clears both outputs. The first access to any granule after reset is remote.
- R9: Back-to-back requests on consecutive cycles to the same granule each see the history left by the previous request.
- R10: Entries at different indices are independent. Traffic to one granule does not change the decisions for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one atomic per cycle |
| req_cpu | input | CPU_W | Identifier of the requesting CPU |
| req_addr | input | ADDR_W | Byte address of the atomic |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_local | output | 1 | 1 = run in requester's L1, 0 = send to outer level |

## Verification
The assertions check the following on every cycle:
- The one-cycle decision timing.
- That a tag miss or an owner change never produces a local decision.
- That a saturated count holds its value.
- That a local decision never appears without a valid one.
- That reset clears every entry.

Some behaviours only the bench's scenarios can show. These are the exact threshold crossing on the third access, the sharing of one entry across every address in a granule, and the eviction of a granule by another tag at the same index. The same holds for isolation between indices, for back-to-back updates, and for the history being lost across a mid-run reset. The bench computes all of these from its own model of the history table.

// File: rtl/apred_pkg.sv
package apred_pkg;
  typedef enum logic {
    PLACE_OUTER = 1'b0,
    PLACE_L1    = 1'b1
  } place_e;

  localparam int unsigned GRANULE_BYTES_DEF = 128;
endpackage

// File: rtl/apred_granule_split.sv
module apred_granule_split #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned GRANULE_BYTES = 128,
  parameter int unsigned ENTRIES       = 16,
  localparam int unsigned OFF_W = $clog2(GRANULE_BYTES),
  localparam int unsigned IDX_W = $clog2(ENTRIES),
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_offset;

  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^addr[OFF_W-1:0];
endmodule

// File: rtl/apred_hist_ram.sv
module apred_hist_ram #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  // Payload without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q      <= '0;
    else if (wr_en) valid_q[idx] <= 1'b1;
  end

  assign rd_data  = mem[idx];
  assign rd_valid = valid_q[idx];

  assert_reset_empty_R8: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0));

  assert_fill_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(idx)]);
endmodule

// File: rtl/apred_update.sv
module apred_update
  import apred_pkg::*;
#(
  parameter int unsigned CPU_W = 3,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned TAG_W = 21,
  parameter int unsigned LIMIT = 2
) (
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [CPU_W-1:0] rd_cpu,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [CPU_W-1:0] req_cpu,
  output logic             hit,
  output logic             same_owner,
  output logic [CNT_W-1:0] nxt_cnt,
  output place_e           place
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   LIM_EXT = (CNT_W+1)'(LIMIT);

  always_comb begin
    hit        = rd_valid && (rd_tag == req_tag);
    same_owner = hit && (rd_cpu == req_cpu);
    if (!same_owner)          nxt_cnt = CNT_ONE;
    else if (rd_cnt == CNT_MAX) nxt_cnt = rd_cnt;
    else                      nxt_cnt = rd_cnt + CNT_ONE;
    place = (same_owner && ({1'b0, nxt_cnt} > LIM_EXT)) ? PLACE_L1 : PLACE_OUTER;
  end
endmodule

// File: rtl/atomic_place_predictor.sv
module atomic_place_predictor
  import apred_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned CPU_W         = 3,
  parameter int unsigned CNT_W         = 3,
  parameter int unsigned ENTRIES       = 16,
  parameter int unsigned GRANULE_BYTES = GRANULE_BYTES_DEF,
  parameter int unsigned LIMIT         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dec_valid,
  output logic              dec_local
);
  localparam int unsigned OFF_W  = $clog2(GRANULE_BYTES);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned DATA_W = TAG_W + CPU_W + CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] wr_data;
  logic [TAG_W-1:0]  rd_tag;
  logic [CPU_W-1:0]  rd_cpu;
  logic [CNT_W-1:0]  rd_cnt;
  logic              hit;
  logic              same_owner;
  logic [CNT_W-1:0]  nxt_cnt;
  place_e            place;
  logic              dec_valid_q;
  logic              dec_local_q;

  apred_granule_split #(
    .ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES), .ENTRIES(ENTRIES)
  ) u_split (
    .addr(req_addr), .idx(idx), .tag(tag)
  );

  apred_hist_ram #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W)
  ) u_ram (
    .clk(clk), .rst(rst), .idx(idx), .wr_en(req_valid),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {rd_tag, rd_cpu, rd_cnt} = rd_data;
  assign wr_data = {tag, req_cpu, nxt_cnt};

  apred_update #(
    .CPU_W(CPU_W), .CNT_W(CNT_W), .TAG_W(TAG_W), .LIMIT(LIMIT)
  ) u_upd (
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_cpu(rd_cpu), .rd_cnt(rd_cnt),
    .req_tag(tag), .req_cpu(req_cpu), .hit(hit), .same_owner(same_owner),
    .nxt_cnt(nxt_cnt), .place(place)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_q <= 1'b0;
      dec_local_q <= 1'b0;
    end else begin
      dec_valid_q <= req_valid;
      dec_local_q <= req_valid && (place == PLACE_L1);
    end
  end

  assign dec_valid = dec_valid_q;
  assign dec_local = dec_local_q;

  assert_dec_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  assert_no_spurious_dec_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);
  assert_local_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    dec_local |-> dec_valid);
  assert_miss_goes_outer_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit) |=> !dec_local);
  assert_owner_change_outer_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && hit && !same_owner) |=> !dec_local);
  assert_restart_count_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !same_owner) |-> (wr_data[CNT_W-1:0] == CNT_W'(1)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && same_owner && rd_cnt == CNT_MAX) |-> (wr_data[CNT_W-1:0] == CNT_MAX));
endmodule

// File: tb/atomic_place_predictor_test.sv
module atomic_place_predictor_test;
  localparam int ADDR_W = 32;
  localparam int CPU_W  = 3;
  localparam int CNT_MAX = 7;
  localparam int ENTRIES = 16;
  localparam int LIMIT  = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [CPU_W-1:0] req_cpu;
  logic [ADDR_W-1:0] req_addr;
  logic dec_valid;
  logic dec_local;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference history model
  bit  m_valid [ENTRIES];
  int  m_tag   [ENTRIES];
  int  m_cpu   [ENTRIES];
  int  m_cnt   [ENTRIES];

  bit    exp_q [$];
  string lbl_q [$];

  atomic_place_predictor uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cpu(req_cpu),
    .req_addr(req_addr), .dec_valid(dec_valid), .dec_local(dec_local)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected decisions as the design produces them
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected dec_valid", 1, 0);
      end else begin
        bit e;
        string l;
        e = exp_q.pop_front();
        l = lbl_q.pop_front();
        check(dec_local == e, l, dec_local, e);
      end
    end
  end

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) m_valid[i] = 0;
  endtask

  task automatic send(input int cpu, input logic [31:0] addr, input string lbl);
    int ix, tg;
    bit loc;
    @(negedge clk); #1;
    ix = int'((addr >> 7) % ENTRIES);
    tg = int'(addr >> 11);
    loc = 0;
    if (m_valid[ix] && m_tag[ix] == tg && m_cpu[ix] == cpu) begin
      if (m_cnt[ix] < CNT_MAX) m_cnt[ix]++;
      loc = (m_cnt[ix] > LIMIT);
    end else begin
      m_valid[ix] = 1; m_tag[ix] = tg; m_cpu[ix] = cpu; m_cnt[ix] = 1;
    end
    exp_q.push_back(loc);
    lbl_q.push_back(lbl);
    req_valid = 1'b1;
    req_cpu   = CPU_W'(cpu);
    req_addr  = addr;
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(dec_valid == 1'b0 || exp_q.size() != 0, "R1 idle dec_valid", dec_valid, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1; req_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check(dec_valid == 1'b0, "R8 reset dec_valid", dec_valid, 0);
    check(dec_local == 1'b0, "R8 reset dec_local", dec_local, 0);
    #1 rst = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0000_1000; // index 0, tag 2
  localparam logic [31:0] B = 32'h0000_1800; // index 0, tag 3
  localparam logic [31:0] C = 32'h0000_1080; // index 1, tag 2

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_cpu = '0; req_addr = '0;
    model_reset();
    do_reset();

    // R3 first touch, R2 same granule via other offsets, R6 threshold
    send(1, A,        "R3 first access remote");
    send(1, A + 4,    "R2 same granule second access");
    send(1, A + 127,  "R6 third access local");
    // R7 saturation: keep going well past counter max
    for (int i = 0; i < 8; i++) send(1, A + 32'(i*8), "R7 saturated stays local");
    // R4 owner change
    send(2, A, "R4 new owner remote");
    send(2, A, "R5 count grows remote");
    send(2, A, "R6 new owner reaches local");
    // R3 tag conflict at same index evicts
    send(2, B, "R3 tag miss remote");
    send(2, A, "R3 evicted granule remote");
    idle(3);
    // R10 independence, R9 interleaved back-to-back traffic
    send(3, C, "R10 other index miss");
    send(2, A, "R10 index0 unaffected");
    send(3, C, "R10 index1 second");
    send(2, A, "R9 back-to-back local");
    send(3, C, "R10 index1 local");
    send(4, A, "R4 interloper remote");
    send(2, A, "R4 previous owner restarts remote");
    idle(2);
    // R8 history lost across reset
    send(3, C, "R9 before reset");
    idle(2);
    do_reset();
    send(3, C, "R8 after reset remote");
    send(3, C, "R8 rebuild second remote");
    send(3, C, "R8 rebuild third local");
    idle(3);
    check(exp_q.size() == 0, "R1 all decisions delivered", exp_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule